// File: doc/BRIEF.md
# Two-Level Address Translator for Hypervisor-Hosted Guests

This block turns 32-bit virtual addresses into physical addresses for a core that runs a hypervisor in kernel mode and guest operating systems in user mode. It has two lookup ports, one for instruction fetches and one for data accesses. Each port has its own three-entry micro-TLB. A micro-TLB miss falls through to a shared, fully associative sixteen-entry table in which each entry covers a pair of adjacent 4 KB pages. Software fills the shared table through a write port. Nothing refills it automatically: an access with no valid mapping is reported as a miss together with its faulting address.

Kernel-mode requests skip translation entirely, and the physical address equals the virtual address. User-mode requests translate over the whole 4 GB range. No region is fixed-mapped and no upper-half range is rejected. A guest can therefore be given its own view of the exception vector area or of device windows purely through table entries.

Top module: `vtlb_xlate`

## Requirements
- R1: A request accepted with `*_req_kern`=1 responds one cycle later with `rsp_paddr` equal to the request address, `rsp_miss`=0 and `rsp_dirty`=1, whatever the table holds.
- R2: A user request whose 4 KB page (address bits 31:12) is held in that port's micro-TLB responds one cycle after acceptance.
- R3: A user request that misses the micro-TLB but matches a shared entry responds two cycles after acceptance. The compare is on bits 31:13. Bit 12=0 selects the even half and bit 12=1 the odd half, and `rsp_paddr` = {half frame number, address bits 11:0}.
- R4: A shared-table hit copies the translated page into the requesting port's micro-TLB, so the next request to that page responds after one cycle.
- R5: A user request that finds no tag match with a valid half responds after two cycles with `rsp_miss`=1, `rsp_paddr`=0 and `rsp_dirty`=0.
- R6: User addresses from 0x8000_0000 to 0xFFFF_FFFF translate through the table like any other address. Without a valid entry they miss, because no fixed mapping exists.
- R7: Each micro-TLB holds three pages and replaces them round-robin. After three fills, a fourth distinct page evicts the oldest of them.
- R8: Any table write empties both micro-TLBs. The next user request to a previously cached page takes two cycles and returns the newly written mapping.
- R9: A table write in the same cycle as a port's shared-table lookup lets that lookup return the mapping held before the write. The following request returns the new mapping after two cycles.
- R10: `exc_valid` rises in the cycle a port responds with a miss and carries that request's address on `exc_vaddr`. `exc_fetch`=1 marks the instruction port. When both ports miss in the same cycle, the data port is reported.
- R11: `rsp_dirty` returns the dirty flag of the half-entry that produced a user translation.
- R12: The two micro-TLBs are filled independently. A page cached for instruction fetches still takes two cycles on its first data access.
- R13: `*_req_ready` is high when idle and after reset, and low during the cycle a port spends on its shared-table lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req_valid | input | 1 | Instruction lookup request |
| if_req_ready | output | 1 | Instruction port can accept |
| if_req_kern | input | 1 | 1 = kernel mode (identity), 0 = user |
| if_req_vaddr | input | 32 | Instruction virtual address |
| if_rsp_valid | output | 1 | Instruction response pulse |
| if_rsp_paddr | output | 32 | Instruction physical address |
| if_rsp_miss | output | 1 | Instruction translation missed |
| if_rsp_dirty | output | 1 | Page dirty flag |
| dt_req_valid | input | 1 | Data lookup request |
| dt_req_ready | output | 1 | Data port can accept |
| dt_req_kern | input | 1 | 1 = kernel mode (identity), 0 = user |
| dt_req_vaddr | input | 32 | Data virtual address |
| dt_rsp_valid | output | 1 | Data response pulse |
| dt_rsp_paddr | output | 32 | Data physical address |
| dt_rsp_miss | output | 1 | Data translation missed |
| dt_rsp_dirty | output | 1 | Page dirty flag |
| tw_en | input | 1 | Write one shared-table entry |
| tw_index | input | 4 | Entry index |
| tw_vpn2 | input | 19 | Page-pair tag (address bits 31:13) |
| tw_pfn_even | input | 20 | Frame number of even page |
| tw_valid_even | input | 1 | Even half valid |
| tw_dirty_even | input | 1 | Even half dirty |
| tw_pfn_odd | input | 20 | Frame number of odd page |
| tw_valid_odd | input | 1 | Odd half valid |
| tw_dirty_odd | input | 1 | Odd half dirty |
| exc_valid | output | 1 | Translation miss exception |
| exc_vaddr | output | 32 | Faulting virtual address |
| exc_fetch | output | 1 | 1 = instruction fetch, 0 = data |

## Verification
Two collisions get directed stimulus. In the first, a table write is timed to land in the very cycle a data request performs its shared-table lookup. The response must carry the old frame, and the next request to that page must take two cycles and carry the new frame. In the second, both ports are given unmapped user addresses in the same cycle, so their misses surface together. The exception output must then name the data address with the fetch flag clear, while each port still flags its own miss.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
    localparam int VA_W    = 32;
    localparam int PAGE_W  = 12;
    localparam int VPN_W   = VA_W - PAGE_W;
    localparam int VPN2_W  = VPN_W - 1;
    localparam int PFN_W   = VPN_W;
    localparam int JTLB_N  = 16;
    localparam int UTLB_N  = 3;
    localparam int JIDX_W  = $clog2(JTLB_N);
    localparam int RR_W    = (UTLB_N > 1) ? $clog2(UTLB_N) : 1;
    localparam int NPORT   = 2;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             v;
        logic             d;
    } jhalf_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        jhalf_t            even;
        jhalf_t            odd;
    } jent_t;

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             d;
    } uent_t;

    typedef struct packed {
        uent_t [UTLB_N-1:0] ent;
        logic  [RR_W-1:0]   rr;
    } micro_st_t;

    typedef enum logic {ST_IDLE, ST_WALK} pstate_e;

    typedef struct packed {
        pstate_e          st;
        logic [VA_W-1:0]  pend;
        logic             rv;
        logic [VA_W-1:0]  pa;
        logic             miss;
        logic             dirty;
    } port_st_t;
endpackage

// File: rtl/vtlb_joint.sv
module vtlb_joint
    import vtlb_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [JIDX_W-1:0]            wr_idx,
    input  jent_t                        wr_ent,
    input  logic [NPORT-1:0][VPN_W-1:0]  lk_vpn,
    output logic [NPORT-1:0]             lk_hit,
    output logic [NPORT-1:0][PFN_W-1:0]  lk_pfn,
    output logic [NPORT-1:0]             lk_dirty
);
    jent_t [JTLB_N-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    // One parallel search per port; lowest index with a valid matching half wins.
    for (genvar p = 0; p < NPORT; p++) begin : g_look
        always_comb begin
            jhalf_t h;
            lk_hit[p]   = 1'b0;
            lk_pfn[p]   = '0;
            lk_dirty[p] = 1'b0;
            for (int i = JTLB_N - 1; i >= 0; i--) begin
                h = lk_vpn[p][0] ? tab_q[i].odd : tab_q[i].even;
                if (tab_q[i].vpn2 == lk_vpn[p][VPN_W-1:1] && h.v) begin
                    lk_hit[p]   = 1'b1;
                    lk_pfn[p]   = h.pfn;
                    lk_dirty[p] = h.d;
                end
            end
        end
    end

    // R8: a written entry is visible to the lookup on the next cycle.
    a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tab_q[$past(wr_idx)] == $past(wr_ent)));
endmodule

// File: rtl/vtlb_micro.sv
module vtlb_micro
    import vtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_dirty,
    input  logic             flush,
    input  logic             fill,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_dirty
);
    micro_st_t q, d;
    logic [UTLB_N-1:0] match;
    logic [UTLB_N-1:0] vld;

    for (genvar k = 0; k < UTLB_N; k++) begin : g_cmp
        assign match[k] = q.ent[k].v && (q.ent[k].vpn == lk_vpn);
        assign vld[k]   = q.ent[k].v;
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_pfn   = '0;
        lk_dirty = 1'b0;
        for (int k = 0; k < UTLB_N; k++) begin
            if (match[k]) begin
                lk_hit   = 1'b1;
                lk_pfn   = q.ent[k].pfn;
                lk_dirty = q.ent[k].d;
            end
        end
    end

    always_comb begin
        d = q;
        if (flush) begin
            for (int k = 0; k < UTLB_N; k++) begin
                d.ent[k].v = 1'b0;
            end
        end else if (fill) begin
            d.ent[q.rr] = '{v: 1'b1, vpn: fill_vpn, pfn: fill_pfn, d: fill_dirty};
            d.rr        = (q.rr == RR_W'(UTLB_N - 1)) ? '0 : q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    a_r7_rr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.rr < RR_W'(UTLB_N));
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0));
endmodule

// File: rtl/vtlb_port.sv
module vtlb_port
    import vtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_kern,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             rsp_miss,
    output logic             rsp_dirty,
    output logic [VA_W-1:0]  rsp_vaddr,
    output logic [VPN_W-1:0] jt_vpn,
    input  logic             jt_hit,
    input  logic [PFN_W-1:0] jt_pfn,
    input  logic             jt_dirty,
    input  logic             tbl_wr
);
    port_st_t q, d;
    logic             u_hit;
    logic [PFN_W-1:0] u_pfn;
    logic             u_dirty;
    logic             fill;

    assign fill = (q.st == ST_WALK) && jt_hit && !tbl_wr;

    vtlb_micro u_micro (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (req_vaddr[VA_W-1:PAGE_W]),
        .lk_hit     (u_hit),
        .lk_pfn     (u_pfn),
        .lk_dirty   (u_dirty),
        .flush      (tbl_wr),
        .fill       (fill),
        .fill_vpn   (q.pend[VA_W-1:PAGE_W]),
        .fill_pfn   (jt_pfn),
        .fill_dirty (jt_dirty)
    );

    always_comb begin
        d      = q;
        d.rv   = 1'b0;
        d.miss = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.pend = req_vaddr;
                    if (req_kern) begin
                        d.rv    = 1'b1;
                        d.pa    = req_vaddr;
                        d.dirty = 1'b1;
                    end else if (u_hit) begin
                        d.rv    = 1'b1;
                        d.pa    = {u_pfn, req_vaddr[PAGE_W-1:0]};
                        d.dirty = u_dirty;
                    end else begin
                        d.st = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                d.st = ST_IDLE;
                d.rv = 1'b1;
                if (jt_hit) begin
                    d.pa    = {jt_pfn, q.pend[PAGE_W-1:0]};
                    d.dirty = jt_dirty;
                end else begin
                    d.pa    = '0;
                    d.dirty = 1'b0;
                    d.miss  = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rv;
    assign rsp_paddr = q.pa;
    assign rsp_miss  = q.miss;
    assign rsp_dirty = q.dirty;
    assign rsp_vaddr = q.pend;
    assign jt_vpn    = q.pend[VA_W-1:PAGE_W];

    a_r1_kernel_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kern) |=>
            (rsp_valid && !rsp_miss && rsp_paddr == $past(req_vaddr)));
    a_r3_walk_responds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (rsp_valid && req_ready));
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss) |-> (rsp_paddr[PAGE_W-1:0] == rsp_vaddr[PAGE_W-1:0]));
    a_r5_miss_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_valid && rsp_paddr == '0 && !rsp_dirty));
endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
    import vtlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_req_valid,
    output logic              if_req_ready,
    input  logic              if_req_kern,
    input  logic [VA_W-1:0]   if_req_vaddr,
    output logic              if_rsp_valid,
    output logic [VA_W-1:0]   if_rsp_paddr,
    output logic              if_rsp_miss,
    output logic              if_rsp_dirty,
    input  logic              dt_req_valid,
    output logic              dt_req_ready,
    input  logic              dt_req_kern,
    input  logic [VA_W-1:0]   dt_req_vaddr,
    output logic              dt_rsp_valid,
    output logic [VA_W-1:0]   dt_rsp_paddr,
    output logic              dt_rsp_miss,
    output logic              dt_rsp_dirty,
    input  logic              tw_en,
    input  logic [JIDX_W-1:0] tw_index,
    input  logic [VPN2_W-1:0] tw_vpn2,
    input  logic [PFN_W-1:0]  tw_pfn_even,
    input  logic              tw_valid_even,
    input  logic              tw_dirty_even,
    input  logic [PFN_W-1:0]  tw_pfn_odd,
    input  logic              tw_valid_odd,
    input  logic              tw_dirty_odd,
    output logic              exc_valid,
    output logic [VA_W-1:0]   exc_vaddr,
    output logic              exc_fetch
);
    localparam int P_IF = 0;
    localparam int P_DT = 1;

    logic [NPORT-1:0][VPN_W-1:0] jt_vpn;
    logic [NPORT-1:0]            jt_hit;
    logic [NPORT-1:0][PFN_W-1:0] jt_pfn;
    logic [NPORT-1:0]            jt_dirty;
    logic [VA_W-1:0]             if_va, dt_va;
    logic                        if_fault, dt_fault;
    jent_t                       wr_ent;

    assign wr_ent = '{vpn2: tw_vpn2,
                      even: '{pfn: tw_pfn_even, v: tw_valid_even, d: tw_dirty_even},
                      odd:  '{pfn: tw_pfn_odd,  v: tw_valid_odd,  d: tw_dirty_odd}};

    vtlb_joint u_joint (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tw_en),
        .wr_idx   (tw_index),
        .wr_ent   (wr_ent),
        .lk_vpn   (jt_vpn),
        .lk_hit   (jt_hit),
        .lk_pfn   (jt_pfn),
        .lk_dirty (jt_dirty)
    );

    vtlb_port u_ifp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (if_req_valid),
        .req_ready (if_req_ready),
        .req_kern  (if_req_kern),
        .req_vaddr (if_req_vaddr),
        .rsp_valid (if_rsp_valid),
        .rsp_paddr (if_rsp_paddr),
        .rsp_miss  (if_rsp_miss),
        .rsp_dirty (if_rsp_dirty),
        .rsp_vaddr (if_va),
        .jt_vpn    (jt_vpn[P_IF]),
        .jt_hit    (jt_hit[P_IF]),
        .jt_pfn    (jt_pfn[P_IF]),
        .jt_dirty  (jt_dirty[P_IF]),
        .tbl_wr    (tw_en)
    );

    vtlb_port u_dtp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (dt_req_valid),
        .req_ready (dt_req_ready),
        .req_kern  (dt_req_kern),
        .req_vaddr (dt_req_vaddr),
        .rsp_valid (dt_rsp_valid),
        .rsp_paddr (dt_rsp_paddr),
        .rsp_miss  (dt_rsp_miss),
        .rsp_dirty (dt_rsp_dirty),
        .rsp_vaddr (dt_va),
        .jt_vpn    (jt_vpn[P_DT]),
        .jt_hit    (jt_hit[P_DT]),
        .jt_pfn    (jt_pfn[P_DT]),
        .jt_dirty  (jt_dirty[P_DT]),
        .tbl_wr    (tw_en)
    );

    // Data misses take precedence when both ports fault together.
    assign if_fault  = if_rsp_valid && if_rsp_miss;
    assign dt_fault  = dt_rsp_valid && dt_rsp_miss;
    assign exc_valid = if_fault || dt_fault;
    assign exc_fetch = !dt_fault && if_fault;
    assign exc_vaddr = dt_fault ? dt_va : (if_fault ? if_va : '0);

    a_r10_data_first: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_rsp_valid && dt_rsp_miss) |-> (exc_valid && !exc_fetch));
    a_r10_fetch_source: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_fetch) |-> (if_rsp_valid && if_rsp_miss));
endmodule

// File: tb/vtlb_xlate_bench.sv
module vtlb_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_req_valid = 1'b0, if_req_kern = 1'b0;
    logic [31:0] if_req_vaddr = '0;
    logic        dt_req_valid = 1'b0, dt_req_kern = 1'b0;
    logic [31:0] dt_req_vaddr = '0;
    logic        if_req_ready, if_rsp_valid, if_rsp_miss, if_rsp_dirty;
    logic [31:0] if_rsp_paddr;
    logic        dt_req_ready, dt_rsp_valid, dt_rsp_miss, dt_rsp_dirty;
    logic [31:0] dt_rsp_paddr;
    logic        tw_en = 1'b0;
    logic [3:0]  tw_index = '0;
    logic [18:0] tw_vpn2 = '0;
    logic [19:0] tw_pfn_even = '0, tw_pfn_odd = '0;
    logic        tw_valid_even = 1'b0, tw_dirty_even = 1'b0;
    logic        tw_valid_odd = 1'b0, tw_dirty_odd = 1'b0;
    logic        exc_valid, exc_fetch;
    logic [31:0] exc_vaddr;

    always #10 clk = ~clk;

    vtlb_xlate u_vtlb_xlate (.*);

    typedef struct {
        logic [31:0] pa;
        logic        miss;
        logic        dirty;
        logic [31:0] va;
        int          issue;
        int          lat;
        string       tag;
    } exp_t;

    exp_t qi[$], qd[$];
    int   n_cmp = 0, n_bad = 0, cyc = 0;
    bit   done = 1'b0;

    logic [18:0] m_vpn2 [16];
    logic [19:0] m_pfn0 [16], m_pfn1 [16];
    logic        m_v0 [16], m_d0 [16], m_v1 [16], m_d1 [16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic exp_t model(logic kern, logic [31:0] va);
        exp_t e;
        e.va = va; e.miss = 1'b1; e.pa = '0; e.dirty = 1'b0;
        if (kern) begin
            e.miss = 1'b0; e.pa = va; e.dirty = 1'b1;
        end else begin
            for (int i = 15; i >= 0; i--) begin
                if (m_vpn2[i] == va[31:13] && (va[12] ? m_v1[i] : m_v0[i])) begin
                    e.miss  = 1'b0;
                    e.pa    = {(va[12] ? m_pfn1[i] : m_pfn0[i]), va[11:0]};
                    e.dirty = va[12] ? m_d1[i] : m_d0[i];
                end
            end
        end
        return e;
    endfunction

    // Driver: waits for ready, predicts the result, queues it, holds valid for one edge.
    task automatic issue(bit dport, logic kern, logic [31:0] va, int lat, string tag);
        exp_t e;
        while (!(dport ? dt_req_ready : if_req_ready)) @(negedge clk);
        e = model(kern, va);
        e.issue = cyc; e.lat = lat; e.tag = tag;
        if (dport) begin
            dt_req_valid = 1'b1; dt_req_kern = kern; dt_req_vaddr = va; qd.push_back(e);
        end else begin
            if_req_valid = 1'b1; if_req_kern = kern; if_req_vaddr = va; qi.push_back(e);
        end
        @(negedge clk);
        if (dport) dt_req_valid = 1'b0; else if_req_valid = 1'b0;
    endtask

    task automatic twrite(int idx, logic [18:0] vpn2, logic [19:0] p0, logic v0, logic d0,
                          logic [19:0] p1, logic v1, logic d1);
        tw_en = 1'b1; tw_index = 4'(idx); tw_vpn2 = vpn2;
        tw_pfn_even = p0; tw_valid_even = v0; tw_dirty_even = d0;
        tw_pfn_odd = p1; tw_valid_odd = v1; tw_dirty_odd = d1;
        m_vpn2[idx] = vpn2; m_pfn0[idx] = p0; m_v0[idx] = v0; m_d0[idx] = d0;
        m_pfn1[idx] = p1; m_v1[idx] = v1; m_d1[idx] = d1;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compares every response against the head of its queue.
    exp_t ei, ed;
    bit   hi, hd;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            hi = 1'b0; hd = 1'b0;
            if (if_rsp_valid) begin
                if (qi.size() == 0) chk("R2", "unexpected fetch response", 32'd1, 32'd0);
                else begin
                    ei = qi.pop_front(); hi = 1'b1;
                    chk(ei.tag, "fetch paddr", if_rsp_paddr, ei.pa);
                    chk(ei.tag, "fetch miss", 32'(if_rsp_miss), 32'(ei.miss));
                    chk(ei.tag, "fetch dirty", 32'(if_rsp_dirty), 32'(ei.dirty));
                    chk(ei.tag, "fetch latency", 32'(cyc - ei.issue), 32'(ei.lat));
                end
            end
            if (dt_rsp_valid) begin
                if (qd.size() == 0) chk("R2", "unexpected data response", 32'd1, 32'd0);
                else begin
                    ed = qd.pop_front(); hd = 1'b1;
                    chk(ed.tag, "data paddr", dt_rsp_paddr, ed.pa);
                    chk(ed.tag, "data miss", 32'(dt_rsp_miss), 32'(ed.miss));
                    chk(ed.tag, "data dirty", 32'(dt_rsp_dirty), 32'(ed.dirty));
                    chk(ed.tag, "data latency", 32'(cyc - ed.issue), 32'(ed.lat));
                end
            end
            if (hd && ed.miss) begin
                chk("R10", "exc_valid", 32'(exc_valid), 32'd1);
                chk("R10", "exc_vaddr", exc_vaddr, ed.va);
                chk("R10", "exc_fetch", 32'(exc_fetch), 32'd0);
            end else if (hi && ei.miss) begin
                chk("R10", "exc_valid", 32'(exc_valid), 32'd1);
                chk("R10", "exc_vaddr", exc_vaddr, ei.va);
                chk("R10", "exc_fetch", 32'(exc_fetch), 32'd1);
            end else if (exc_valid) begin
                chk("R10", "spurious exc_valid", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        wait (cyc > 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_vpn2[i] = '0; m_pfn0[i] = '0; m_pfn1[i] = '0;
            m_v0[i] = 1'b0; m_d0[i] = 1'b0; m_v1[i] = 1'b0; m_d1[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13", "reset if_ready", 32'(if_req_ready), 32'd1);
        chk("R13", "reset dt_ready", 32'(dt_req_ready), 32'd1);
        chk("R13", "reset rsp_valid", 32'({if_rsp_valid, dt_rsp_valid}), 32'd0);
        chk("R10", "reset exc_valid", 32'(exc_valid), 32'd0);

        twrite(0, 19'h00200, 20'h12345, 1, 1, 20'h0ABCD, 1, 0);
        twrite(5, 19'h40000, 20'h00777, 1, 0, 20'h00000, 0, 0);
        twrite(9, 19'h08000, 20'h00100, 1, 0, 20'h00101, 1, 1);

        issue(0, 0, 32'h0000_1000, 2, "R5");          // unmapped fetch
        issue(0, 1, 32'h8000_0180, 1, "R1");          // kernel identity
        issue(0, 0, 32'h0040_0010, 2, "R3");          // even half, via shared table
        chk("R13", "ready during walk", 32'(if_req_ready), 32'd0);
        issue(0, 0, 32'h0040_0FFC, 1, "R4");          // refilled page
        issue(0, 0, 32'h0040_1008, 2, "R3");          // odd half, R11 dirty=0
        issue(1, 0, 32'h0040_0020, 2, "R12");         // data micro is separate
        issue(0, 0, 32'h0040_1010, 1, "R2");
        issue(1, 1, 32'hFFFF_E000, 1, "R1");
        issue(1, 0, 32'h8000_0180, 2, "R6");          // upper half translated
        issue(1, 0, 32'h8000_1000, 2, "R5");          // tag matches, half invalid
        issue(1, 0, 32'hFFFF_E000, 2, "R6");          // no fixed segment
        drain();

        twrite(15, 19'h00000, 20'h0, 0, 0, 20'h0, 0, 0);  // flush micros
        issue(1, 0, 32'h1000_0000, 2, "R7");  // A
        issue(1, 0, 32'h1000_1000, 2, "R7");  // B, R11 dirty=1
        issue(1, 0, 32'h0040_0000, 2, "R7");  // C
        issue(1, 0, 32'h1000_0004, 1, "R7");
        issue(1, 0, 32'h1000_1004, 1, "R7");
        issue(1, 0, 32'h0040_0004, 1, "R7");
        issue(1, 0, 32'h0040_1000, 2, "R7");  // D evicts A
        issue(1, 0, 32'h1000_0008, 2, "R7");  // A evicts B
        issue(1, 0, 32'h0040_0008, 1, "R7");  // C still held
        issue(1, 0, 32'h1000_1008, 2, "R7");  // B evicts C
        issue(1, 0, 32'h0040_1004, 1, "R7");  // D still held
        drain();

        twrite(9, 19'h08000, 20'h00200, 1, 0, 20'h00101, 1, 1);
        issue(1, 0, 32'h1000_0010, 2, "R8");
        issue(0, 0, 32'h0040_1010, 2, "R8");
        drain();

        fork
            issue(1, 0, 32'h1000_1234, 2, "R9");
            begin
                @(negedge clk);
                twrite(9, 19'h08000, 20'h00200, 1, 0, 20'h00300, 1, 0);
            end
        join
        issue(1, 0, 32'h1000_1238, 2, "R9");
        drain();

        fork
            issue(0, 0, 32'h5000_0000, 2, "R10");
            issue(1, 0, 32'h6000_0004, 2, "R10");
        join
        drain();

        chk("R2", "pending fetch items", 32'(qi.size()), 32'd0);
        chk("R2", "pending data items", 32'(qd.size()), 32'd0);
        summary();
    end
endmodule